// File: doc/BRIEF.md
# Asynchronous NAND Strobe Sequencer

This block turns single host read and write requests into timed byte cycles on an external 8-bit NAND bus. Every byte cycle walks through four phases (setup, strobe, hold, turnaround). The length of each phase comes from a field of one 32-bit configuration word. Read and write accesses have separate setup, strobe and hold fields, and share one turnaround field.

Two host address bits choose the kind of byte cycle: command latch, address latch or plain data. The two lowest address bits play no part. A wide request is split into four byte cycles that run back to back.

Each chipselect has its own mode bit, and a request is only run when that bit marks the chipselect as NAND. A die-select flag ORs a mask into the outgoing address so that a second die can be reached. The ready/busy line is shared by all devices in a wire-AND. It is synchronised and presented as a status bit, and it never stretches a strobe.

Top module: `nand_strobe_seq`

## Requirements
- R1: Each byte cycle runs setup, then strobe low, then hold, then turnaround, and each phase lasts its field value plus one clock. The configuration word fields are: write setup [29:26], write strobe [25:20], write hold [19:17], read setup [16:13], read strobe [12:7], read hold [6:4] and turnaround [3:2].
- R2: The chip enable for `req_cs` is low through setup, strobe and hold, and high in turnaround. When configuration bit 31 (strobe-only enable) is set, it is low only during the strobe phase. No other chip enable goes low.
- R3: Address bit 4 set gives a command-latch cycle (`nand_cle`=1). Bit 3 set with bit 4 clear gives an address-latch cycle (`nand_ale`=1). Neither bit set gives a data cycle. The two latch outputs are never high together.
- R4: With `req_wide`=1 the access runs four byte cycles back to back, lowest byte (bits 7:0) first. With `req_wide`=0 it runs one. Address bits [1:0] affect neither the latch outputs nor `nand_addr`, whose bits [1:0] are always 0.
- R5: On a write, `nand_dq_oe` is high and `nand_dq_out` carries the current byte from setup through hold. On a read, `nand_dq_in` is captured in the last strobe cycle into the current byte lane. `resp_valid` pulses in the cycle after the last turnaround cycle, with the assembled word on `resp_rdata` (upper lanes 0 for a one-byte read).
- R6: `nand_rdy` passes through two flops before it reaches `status_ready` (1 = all devices ready, 0 = busy). `status_ready` is 0 after reset.
- R7: Configuration bit 30 (extended wait), the bus-size field [1:0] and the level of `nand_rdy` have no effect on phase lengths.
- R8: A request to a chipselect whose `nand_cs_mode` bit is 0 drives no strobe and no chip enable. Its `resp_valid` comes one cycle after acceptance, with `resp_rdata`=0.
- R9: With `req_die`=1, `die_mask` is ORed into the address presented on `nand_addr`.
- R10: After reset all chip enables and strobes are high, `nand_dq_oe` is 0 and `req_ready` is 1. `req_ready` is 0 while a byte sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_word | input | 32 | Packed timing and mode configuration |
| nand_cs_mode | input | NUM_CS | Per-chipselect NAND mode enable |
| die_mask | input | ADDR_W | Mask ORed into the address for the second die |
| req_valid | input | 1 | Host request strobe |
| req_ready | output | 1 | Sequencer idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = four byte cycles, 0 = one |
| req_cs | input | CS_W | Target chipselect |
| req_die | input | 1 | Select the second die |
| req_addr | input | ADDR_W | Host byte address |
| req_wdata | input | DATA_W | Write data, lowest byte sent first |
| resp_valid | output | 1 | Access complete pulse |
| resp_rdata | output | DATA_W | Assembled read data |
| nand_ce_n | output | NUM_CS | Active-low chip enables |
| nand_addr | output | ADDR_W | External address with die mask applied |
| nand_ale | output | 1 | Address latch enable |
| nand_cle | output | 1 | Command latch enable |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_out | output | 8 | Data driven to the devices |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Data from the devices |
| nand_rdy | input | 1 | Wire-ANDed ready/busy line |
| status_ready | output | 1 | Synchronised ready status |

## Verification
The bench sets each phase field to different values and counts strobe, chip-enable and output-enable cycles. A design that loads a read field on a write, or drops the plus-one, shows up as a wrong count or a wrong total latency. It sends a request with both latch bits set and with nonzero low address bits; a wrong priority raises ALE on a command, and leaking low bits changes `nand_addr`. It runs wide reads and writes with data that changes per byte, so a lane reversal or a capture taken one cycle late corrupts the word. It also checks the one-flop-short synchroniser, a request to a non-NAND chipselect, the die mask, and strobe-only enable mode.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;

  // Bit order of this struct follows the configuration word, MSB first.
  typedef struct packed {
    logic       sel_strobe;
    logic       ext_wait;
    logic [3:0] wr_setup;
    logic [5:0] wr_strobe;
    logic [2:0] wr_hold;
    logic [3:0] rd_setup;
    logic [5:0] rd_strobe;
    logic [2:0] rd_hold;
    logic [1:0] turn;
    logic [1:0] bus_size;
  } nand_cfg_t;

  // Counter load value for a phase; the phase lasts this value plus one clock.
  function automatic logic [5:0] phase_count(nand_cfg_t c, logic wr, phase_e ph);
    case (ph)
      PH_SETUP:  return wr ? {2'b00, c.wr_setup} : {2'b00, c.rd_setup};
      PH_STROBE: return wr ? c.wr_strobe : c.rd_strobe;
      PH_HOLD:   return wr ? {3'b000, c.wr_hold} : {3'b000, c.rd_hold};
      PH_TURN:   return {4'b0000, c.turn};
      default:   return 6'd0;
    endcase
  endfunction

  function automatic phase_e phase_next(phase_e ph);
    case (ph)
      PH_SETUP:  return PH_STROBE;
      PH_STROBE: return PH_HOLD;
      PH_HOLD:   return PH_TURN;
      default:   return PH_SETUP;
    endcase
  endfunction

  // Phases in which the device sees an active cycle.
  function automatic logic phase_active(phase_e ph);
    return (ph == PH_SETUP) || (ph == PH_STROBE) || (ph == PH_HOLD);
  endfunction

  // Returns {cle, ale}; the command latch wins when both bits are set.
  function automatic logic [1:0] latch_select(logic a3, logic a4);
    return {a4, a3 & ~a4};
  endfunction

endpackage

// File: rtl/nand_rdy_sync.sv
module nand_rdy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_async,
  output logic rdy_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], rdy_async};
  end

  assign rdy_sync = chain_q[STAGES-1];
endmodule

// File: rtl/nand_phase_timer.sv
module nand_phase_timer
  import nand_seq_pkg::*;
#(
  parameter int BYTE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nand_cfg_t         cfg,
  input  logic              start,
  input  logic              start_wr,
  input  logic [BYTE_W-1:0] start_last,
  output phase_e            phase,
  output logic              cur_wr,
  output logic [BYTE_W-1:0] byte_idx,
  output logic              last_strobe,
  output logic              seq_done
);
  logic [5:0]        cnt_q;
  logic [BYTE_W-1:0] last_q;
  logic              byte_final;

  assign byte_final  = (byte_idx == last_q);
  assign last_strobe = (phase == PH_STROBE) && (cnt_q == 6'd0);
  assign seq_done    = (phase == PH_TURN) && (cnt_q == 6'd0) && byte_final;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      cnt_q    <= '0;
      byte_idx <= '0;
      last_q   <= '0;
      cur_wr   <= 1'b0;
    end else if (phase == PH_IDLE) begin
      if (start) begin
        phase    <= PH_SETUP;
        cnt_q    <= phase_count(cfg, start_wr, PH_SETUP);
        cur_wr   <= start_wr;
        byte_idx <= '0;
        last_q   <= start_last;
      end
    end else if (cnt_q != 6'd0) begin
      cnt_q <= cnt_q - 6'd1;
    end else if (seq_done) begin
      phase <= PH_IDLE;
    end else begin
      phase <= phase_next(phase);
      cnt_q <= phase_count(cfg, cur_wr, phase_next(phase));
      if (phase == PH_TURN) byte_idx <= byte_idx + 1'b1;
    end
  end
endmodule

// File: rtl/nand_addr_decode.sv
module nand_addr_decode
  import nand_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2,
  parameter int ADDR_W = 24
) (
  input  phase_e            phase,
  input  logic              sel_strobe,
  input  logic [CS_W-1:0]   cs,
  input  logic [ADDR_W-1:0] addr,
  input  logic              die,
  input  logic [ADDR_W-1:0] die_mask,
  output logic [NUM_CS-1:0] ce_n,
  output logic              ale,
  output logic              cle,
  output logic [ADDR_W-1:0] addr_out
);
  logic              ce_on;
  logic              cyc_on;
  logic [1:0]        kind;
  logic [ADDR_W-1:0] full_addr;
  logic              addr_lsb_unused;

  assign cyc_on = phase_active(phase);
  assign ce_on  = sel_strobe ? (phase == PH_STROBE) : cyc_on;

  for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
    assign ce_n[g] = ~(ce_on && (cs == CS_W'(g)));
  end

  assign kind = latch_select(addr[3], addr[4]);
  assign cle  = cyc_on & kind[1];
  assign ale  = cyc_on & kind[0];

  assign full_addr       = addr | (die ? die_mask : '0);
  assign addr_out        = {full_addr[ADDR_W-1:2], 2'b00};
  assign addr_lsb_unused = ^addr[1:0];
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_seq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int BYTES = DATA_W / 8,
  localparam int BYTE_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_word,
  input  logic [NUM_CS-1:0] nand_cs_mode,
  input  logic [ADDR_W-1:0] die_mask,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [CS_W-1:0]   req_cs,
  input  logic              req_die,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_rdata,
  output logic [NUM_CS-1:0] nand_ce_n,
  output logic [ADDR_W-1:0] nand_addr,
  output logic              nand_ale,
  output logic              nand_cle,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [7:0]        nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [7:0]        nand_dq_in,
  input  logic              nand_rdy,
  output logic              status_ready
);
  nand_cfg_t         cfg_s;
  phase_e            phase_cur;
  logic              cur_wr;
  logic [BYTE_W-1:0] byte_idx;
  logic              last_strobe;
  logic              seq_done;
  logic              accept;
  logic              mode_hit;
  logic              start;
  logic [BYTE_W-1:0] start_last;
  logic [CS_W-1:0]   cs_q;
  logic              die_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              cfg_unused;

  assign cfg_s      = nand_cfg_t'(cfg_word);
  assign cfg_unused = ^{cfg_s.ext_wait, cfg_s.bus_size};

  assign req_ready  = (phase_cur == PH_IDLE);
  assign accept     = req_valid && req_ready;
  assign mode_hit   = nand_cs_mode[req_cs];
  assign start      = accept && mode_hit;
  assign start_last = req_wide ? BYTE_W'(BYTES - 1) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= '0;
      die_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      cs_q    <= req_cs;
      die_q   <= req_die;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q    <= '0;
      resp_valid <= 1'b0;
    end else begin
      resp_valid <= seq_done || (accept && !mode_hit);
      if (accept)
        rdata_q <= '0;
      else if (last_strobe && !cur_wr)
        rdata_q[byte_idx*8 +: 8] <= nand_dq_in;
    end
  end

  assign resp_rdata = rdata_q;

  nand_phase_timer #(.BYTE_W(BYTE_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg        (cfg_s),
    .start      (start),
    .start_wr   (req_write),
    .start_last (start_last),
    .phase      (phase_cur),
    .cur_wr     (cur_wr),
    .byte_idx   (byte_idx),
    .last_strobe(last_strobe),
    .seq_done   (seq_done)
  );

  nand_addr_decode #(.NUM_CS(NUM_CS), .CS_W(CS_W), .ADDR_W(ADDR_W)) u_decode (
    .phase     (phase_cur),
    .sel_strobe(cfg_s.sel_strobe),
    .cs        (cs_q),
    .addr      (addr_q),
    .die       (die_q),
    .die_mask  (die_mask),
    .ce_n      (nand_ce_n),
    .ale       (nand_ale),
    .cle       (nand_cle),
    .addr_out  (nand_addr)
  );

  assign nand_we_n   = ~((phase_cur == PH_STROBE) && cur_wr);
  assign nand_re_n   = ~((phase_cur == PH_STROBE) && !cur_wr);
  assign nand_dq_oe  = cur_wr && phase_active(phase_cur);
  assign nand_dq_out = wdata_q[byte_idx*8 +: 8];

  nand_rdy_sync #(.STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .rdy_async(nand_rdy),
    .rdy_sync (status_ready)
  );
endmodule

// File: rtl/nand_strobe_seq_chk.sv
module nand_strobe_seq_chk #(
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [5:0]        wr_strobe_cfg,
  input logic [5:0]        rd_strobe_cfg,
  input logic [NUM_CS-1:0] nand_ce_n,
  input logic              nand_we_n,
  input logic              nand_re_n,
  input logic              nand_ale,
  input logic              nand_cle,
  input logic              nand_dq_oe,
  input logic              req_ready,
  input logic              nand_rdy,
  input logic              status_ready,
  input logic              cur_wr
);
  logic       strobe_low;
  logic [7:0] low_cnt;
  logic [1:0] since_rst;

  assign strobe_low = !nand_we_n || !nand_re_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      since_rst <= '0;
    end else begin
      low_cnt <= strobe_low ? low_cnt + 8'd1 : 8'd0;
      if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end
  end

  assert_strobe_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));

  assert_strobe_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_low && low_cnt != 8'd0) |->
      low_cnt == (cur_wr ? 8'(wr_strobe_cfg) + 8'd1 : 8'(rd_strobe_cfg) + 8'd1));

  assert_ce_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nand_ce_n));

  assert_ce_in_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |-> !(&nand_ce_n));

  assert_latch_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_ale && nand_cle));

  assert_oe_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    nand_dq_oe |-> nand_re_n);

  assert_sync_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2) |-> (status_ready == $past(nand_rdy, 2)));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_we_n && nand_re_n && (&nand_ce_n) && !nand_dq_oe));
endmodule

bind nand_strobe_seq nand_strobe_seq_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_strobe_cfg(cfg_word[25:20]),
  .rd_strobe_cfg(cfg_word[12:7]),
  .nand_ce_n    (nand_ce_n),
  .nand_we_n    (nand_we_n),
  .nand_re_n    (nand_re_n),
  .nand_ale     (nand_ale),
  .nand_cle     (nand_cle),
  .nand_dq_oe   (nand_dq_oe),
  .req_ready    (req_ready),
  .nand_rdy     (nand_rdy),
  .status_ready (status_ready),
  .cur_wr       (cur_wr)
);

// File: tb/test_nand_strobe_seq.sv
module test_nand_strobe_seq;
  localparam int NUM_CS = 4;
  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [31:0]       cfg_word = '0;
  logic [NUM_CS-1:0] nand_cs_mode = '1;
  logic [ADDR_W-1:0] die_mask = '0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic              req_wide = 1'b0;
  logic [1:0]        req_cs = '0;
  logic              req_die = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              resp_valid;
  logic [DATA_W-1:0] resp_rdata;
  logic [NUM_CS-1:0] nand_ce_n;
  logic [ADDR_W-1:0] nand_addr;
  logic              nand_ale, nand_cle, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]        nand_dq_out;
  logic [7:0]        nand_dq_in = '0;
  logic              nand_rdy = 1'b0;
  logic              status_ready;

  always #2 clk = ~clk;

  nand_strobe_seq i_nand_strobe_seq (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .nand_cs_mode(nand_cs_mode),
    .die_mask(die_mask), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_wide(req_wide), .req_cs(req_cs), .req_die(req_die),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_rdata(resp_rdata), .nand_ce_n(nand_ce_n), .nand_addr(nand_addr),
    .nand_ale(nand_ale), .nand_cle(nand_cle), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rdy(nand_rdy), .status_ready(status_ready)
  );

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(bit sel, bit ew, int ws, int wt, int wh,
                                         int rs, int rt, int rh, int ta, int bs);
    logic [31:0] v;
    v = '0;
    v[31] = sel; v[30] = ew;
    v[29:26] = 4'(ws); v[25:20] = 6'(wt); v[19:17] = 3'(wh);
    v[16:13] = 4'(rs); v[12:7] = 6'(rt); v[6:4] = 3'(rh);
    v[3:2] = 2'(ta); v[1:0] = 2'(bs);
    return v;
  endfunction

  // Measured during one access
  int          m_cyc, m_strobe, m_ce, m_ce_other, m_oe, m_ale, m_cle, m_busy;
  logic [31:0] m_wword, m_rdata;
  logic [ADDR_W-1:0] m_addr;

  task automatic run_access(input int wr, input int wide, input int cs, input int die,
                            input int addr, input logic [31:0] wdata, input int dqb);
    int byte_k;
    bit prev_strobe, strobe;
    @(negedge clk);
    req_write = wr[0]; req_wide = wide[0]; req_cs = 2'(cs); req_die = die[0];
    req_addr = ADDR_W'(addr); req_wdata = wdata; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    m_cyc = 0; m_strobe = 0; m_ce = 0; m_ce_other = 0; m_oe = 0; m_ale = 0; m_cle = 0;
    m_wword = '0; m_rdata = '0; byte_k = 0; prev_strobe = 0;
    m_busy = !req_ready; m_addr = nand_addr;
    nand_dq_in = 8'(dqb);
    for (int c = 1; c <= 600; c++) begin
      if (resp_valid) begin
        m_cyc = c; m_rdata = resp_rdata;
        break;
      end
      strobe = !nand_we_n || !nand_re_n;
      if (strobe) begin
        m_strobe++;
        if (nand_ale) m_ale = 1;
        if (nand_cle) m_cle = 1;
      end
      if (!nand_we_n) m_wword[byte_k*8 +: 8] = nand_dq_out;
      if (!nand_ce_n[cs]) m_ce++;
      for (int g = 0; g < NUM_CS; g++)
        if (g != cs && !nand_ce_n[g]) m_ce_other++;
      if (nand_dq_oe) m_oe++;
      if (prev_strobe && !strobe) begin
        byte_k++;
        nand_dq_in = 8'(dqb + byte_k);
      end
      prev_strobe = strobe;
      @(negedge clk);
    end
  endtask

  // Stimulus / expectation table: one access per row
  localparam int NV = 6;
  localparam int V_WR  [NV] = '{1,    1,    0,    1,          0,    1};
  localparam int V_WIDE[NV] = '{0,    0,    0,    1,          1,    0};
  localparam int V_ADDR[NV] = '{'h10, 'h08, 'h00, 'h03,       'h00, 'h18};
  localparam int V_DATA[NV] = '{'h70, 'h3C, 0,    'h44332211, 0,    'hE0};
  localparam int V_DQB [NV] = '{0,    0,    'hA5, 0,          'h10, 0};
  localparam int V_S   [NV] = '{1,    0,    2,    1,          0,    3};
  localparam int V_T   [NV] = '{2,    0,    3,    1,          4,    1};
  localparam int V_H   [NV] = '{0,    0,    1,    2,          0,    1};
  localparam int V_A   [NV] = '{1,    0,    2,    0,          3,    1};
  localparam int V_EW  [NV] = '{0,    0,    0,    0,          0,    1};
  localparam int V_CLE [NV] = '{1,    0,    0,    0,          0,    1};
  localparam int V_ALE [NV] = '{0,    1,    0,    0,          0,    0};

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 ce_n after reset", 32'(nand_ce_n), 32'hF);
    chk("R10 strobes after reset", {30'd0, nand_we_n, nand_re_n}, 32'd3);
    chk("R10 dq_oe after reset", 32'(nand_dq_oe), 0);
    chk("R10 req_ready after reset", 32'(req_ready), 1);
    chk("R6 status_ready after reset", 32'(status_ready), 0);

    // R6 two-flop synchroniser latency
    nand_rdy = 1'b1;
    @(negedge clk);
    chk("R6 status one cycle after ready", 32'(status_ready), 0);
    @(negedge clk);
    chk("R6 status two cycles after ready", 32'(status_ready), 1);
    nand_rdy = 1'b0;
    @(negedge clk);
    chk("R6 busy one cycle", 32'(status_ready), 1);
    @(negedge clk);
    chk("R6 busy two cycles", 32'(status_ready), 0);
    nand_rdy = 1'b1;
    repeat (2) @(negedge clk);

    // Table walk: R1 R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      int n, per, act;
      logic [31:0] exp_w;
      n = V_WIDE[v] ? 4 : 1;
      if (V_WR[v])
        cfg_word = mk_cfg(0, V_EW[v][0], V_S[v], V_T[v], V_H[v], 2, 5, 1, V_A[v], V_EW[v] ? 3 : 0);
      else
        cfg_word = mk_cfg(0, V_EW[v][0], 3, 7, 2, V_S[v], V_T[v], V_H[v], V_A[v], 0);
      nand_rdy = V_EW[v] ? 1'b0 : 1'b1;
      run_access(V_WR[v], V_WIDE[v], 0, 0, V_ADDR[v], V_DATA[v], V_DQB[v]);
      per = V_S[v] + V_T[v] + V_H[v] + V_A[v] + 4;
      act = V_S[v] + V_T[v] + V_H[v] + 3;
      chk($sformatf("R1 R7 latency row %0d", v), m_cyc, n * per + 1);
      chk($sformatf("R1 strobe cycles row %0d", v), m_strobe, n * (V_T[v] + 1));
      chk($sformatf("R2 ce low cycles row %0d", v), m_ce, n * act);
      chk($sformatf("R2 other ce row %0d", v), m_ce_other, 0);
      chk($sformatf("R3 cle row %0d", v), m_cle, V_CLE[v]);
      chk($sformatf("R3 ale row %0d", v), m_ale, V_ALE[v]);
      chk($sformatf("R10 busy row %0d", v), m_busy, 1);
      chk($sformatf("R4 addr low bits row %0d", v), 32'(m_addr), V_ADDR[v] & 'hFFFFFC);
      if (V_WR[v]) begin
        exp_w = V_WIDE[v] ? 32'(V_DATA[v]) : {24'd0, 8'(V_DATA[v])};
        chk($sformatf("R5 R4 write bytes row %0d", v), m_wword, exp_w);
        chk($sformatf("R5 oe cycles row %0d", v), m_oe, n * act);
      end else begin
        exp_w = '0;
        for (int b = 0; b < n; b++) exp_w[b*8 +: 8] = 8'(V_DQB[v] + b);
        chk($sformatf("R5 R4 read word row %0d", v), m_rdata, exp_w);
        chk($sformatf("R5 oe on read row %0d", v), m_oe, 0);
      end
    end
    nand_rdy = 1'b1;

    // R2 strobe-only chip enable mode
    cfg_word = mk_cfg(1, 0, 0, 0, 0, 1, 2, 1, 0, 0);
    run_access(0, 0, 2, 0, 'h00, 0, 'h5A);
    chk("R2 strobe-only ce cycles", m_ce, 3);
    chk("R2 strobe-only latency", m_cyc, 9);
    chk("R2 strobe-only read data", m_rdata, 32'h5A);

    // R8 chipselect not in NAND mode
    cfg_word = mk_cfg(0, 0, 1, 1, 1, 1, 1, 1, 1, 0);
    nand_cs_mode = 4'b0101;
    run_access(1, 1, 1, 0, 'h00, 32'hDEADBEEF, 0);
    chk("R8 non-nand latency", m_cyc, 1);
    chk("R8 non-nand strobes", m_strobe, 0);
    chk("R8 non-nand ce", m_ce + m_ce_other, 0);
    chk("R8 non-nand rdata", m_rdata, 0);
    nand_cs_mode = '1;

    // R9 die mask, R4 low bits ignored on a second chipselect
    die_mask = 24'h100000;
    run_access(1, 0, 3, 1, 'h13, 32'h90, 0);
    chk("R9 die mask on addr", 32'(m_addr), 32'h100010);
    chk("R3 R4 cle with low bits", m_cle, 1);
    chk("R2 ce on cs3", m_ce, 6);
    run_access(1, 0, 3, 0, 'h0B, 32'h01, 0);
    chk("R9 no die mask", 32'(m_addr), 32'h000008);
    chk("R3 ale with low bits", m_ale, 1);
    chk("R3 no cle on ale cycle", m_cle, 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule